// File: doc/BRIEF.md
# Configurable memory chip-enable decoder

This block turns a 24-bit access address into active-low enables for up to eight equal, contiguous memory banks. A small set of configuration registers chooses the bank size. The same registers choose how many of the low four and the high four enable pins act as chip enables, with the remaining pins left as general I/O. They also choose, for each of the low four banks, whether the program enable doubles as the peripheral enable for data accesses.

Each cycle the address and a fetch/data qualifier are decoded. The result appears on the registered enable outputs one clock later. The pin-mode outputs follow the configuration registers directly, so software-visible pin ownership changes on the cycle after a register write.

Top module: `cedec_top`

## Requirements
- R1: After a synchronous reset every configuration field is zero: bank size 32K, all eight pins report I/O (`pin_is_ce` = 0), and all `ce_n` and `pce_n` outputs are high.
- R2: The size code (register select 0, data bits 2:0) gives the bank size S: 0→32K, 1→128K, 2→256K, 3→512K, 4→1M, 5→2M, 6 or 7→4M. Enable n covers addresses n·S through (n+1)·S−1, with bank 0 starting at address 0.
- R3: With the 4M size, only enables 0–3 can ever go low; enables 4–7 stay high for every address.
- R4: At most one `ce_n` bit is low in any cycle, and none is low for an address at or above 8·S.
- R5: The low pin code (register select 1, data bits 2:0) drives pins 0–3: 100 enables pin 0, 101 enables pins 0–1, 110 enables pins 0–2, 111 enables pins 0–3, and any code with bit 2 clear leaves all four as I/O.
- R6: The high pin code (register select 2, data bits 2:0) uses the same progressive encoding for pins 4–7 and is independent of the low code.
- R7: A pin in I/O mode reports 0 on `pin_is_ce` and keeps its `ce_n` high for every address and access type.
- R8: A program access (`fetch_is_prog`=1) in bank n lowers `ce_n[n]` when that pin is a chip enable. A data access in bank x (x<4) whose merge bit is clear lowers `pce_n[x]` whatever the pin mode, and lowers no `ce_n`.
- R9: When merge bit x (register select 3, data bit x) is set, a data access in bank x lowers `ce_n[x]` (if the pin is enabled) and `pce_n[x]` stays high.
- R10: `ce_n` and `pce_n` reflect the address and qualifier presented one clock edge earlier, and hold until the next edge.
- R11: A register changes only on a clock edge with `cfg_wr_en` high. Otherwise the data and select inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_wr_en | input | 1 | Configuration write strobe |
| cfg_wr_sel | input | 2 | Register select: 0 size, 1 low pins, 2 high pins, 3 merge bits |
| cfg_wr_data | input | 4 | Write data |
| fetch_addr | input | 24 | Access address |
| fetch_is_prog | input | 1 | 1 = program fetch, 0 = data/peripheral access |
| ce_n | output | 8 | Active-low chip enables, registered |
| pce_n | output | 4 | Active-low peripheral enables, registered |
| pin_is_ce | output | 8 | 1 = pin carries a chip enable, 0 = I/O |

## Verification
An address and qualifier driven on a falling edge produce enables after the next rising edge. The bench therefore samples `ce_n` and `pce_n` on the falling edge that follows, exactly one period after driving. Once, it also samples just after driving, to confirm the previous result is still held. A configuration write driven on a falling edge becomes visible on `pin_is_ce` by the next falling edge. Because the enable registers sample the configuration on the same edge as the address, every write completes a full cycle before the addresses that depend on it are applied. Expected values come from arithmetic on bank size, bank index and progressive pin counts, swept over every size code, every pair of pin codes and every merge pattern.

// File: rtl/cedec_pkg.sv
`timescale 1ns/1ps
// Package: shared register selects and the size-code decode used by the
// chip-enable decoder. Assumes the smallest bank is 32K (2^15 bytes).
package cedec_pkg;

    typedef enum logic [1:0] {
        CFG_SIZE  = 2'd0,
        CFG_LOW   = 2'd1,
        CFG_HIGH  = 2'd2,
        CFG_MERGE = 2'd3
    } cfg_reg_e;

    localparam int MIN_BANK_LOG2 = 15;

    // Map a 3-bit size code to log2 of the bank size in bytes.
    function automatic logic [4:0] bank_log2(input logic [2:0] code);
        logic [4:0] r;
        case (code)
            3'd0:    r = 5'(MIN_BANK_LOG2);
            3'd1:    r = 5'(MIN_BANK_LOG2 + 2);
            3'd2:    r = 5'(MIN_BANK_LOG2 + 3);
            3'd3:    r = 5'(MIN_BANK_LOG2 + 4);
            3'd4:    r = 5'(MIN_BANK_LOG2 + 5);
            3'd5:    r = 5'(MIN_BANK_LOG2 + 6);
            default: r = 5'(MIN_BANK_LOG2 + 7);
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cedec_cfg_regs.sv
`timescale 1ns/1ps
// Module: configuration register file for the chip-enable decoder.
// Holds the size code, the two progressive pin codes and the merge bits.
// Assumes a single write port; writes land on the rising edge with wr_en high.
module cedec_cfg_regs
    import cedec_pkg::*;
#(
    parameter int N_MERGE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_sel,
    input  logic [N_MERGE-1:0] wr_data,
    output logic [2:0]         size_code,
    output logic [2:0]         low_code,
    output logic [2:0]         high_code,
    output logic [N_MERGE-1:0] merge_bits
);

    // Register update: clear on reset, otherwise load the selected field.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            size_code  <= '0;
            low_code   <= '0;
            high_code  <= '0;
            merge_bits <= '0;
        end else if (wr_en) begin
            case (cfg_reg_e'(wr_sel))
                CFG_SIZE:  size_code  <= wr_data[2:0];
                CFG_LOW:   low_code   <= wr_data[2:0];
                CFG_HIGH:  high_code  <= wr_data[2:0];
                default:   merge_bits <= wr_data;
            endcase
        end
    end

    // R1: the cycle after reset every field reads zero.
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (size_code == 3'd0 && low_code == 3'd0 &&
                           high_code == 3'd0 && merge_bits == '0));

    // R11: without a write strobe nothing changes.
    p_hold_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en) && $past(rst_n)) |->
            ($stable(size_code) && $stable(low_code) &&
             $stable(high_code) && $stable(merge_bits)));

endmodule

// File: rtl/cedec_bank_sel.sv
`timescale 1ns/1ps
// Module: combinational bank match. Shifts the address right by log2 of
// the bank size and compares the result with each enable index. An
// address beyond the last bank matches nothing.
module cedec_bank_sel
    import cedec_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int N_CE   = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [2:0]        size_code,
    output logic [N_CE-1:0]   hit
);

    logic [ADDR_W-1:0] bank_idx;

    // Bank index: address divided by the bank size.
    always_comb bank_idx = addr >> bank_log2(size_code);

    genvar g;
    generate
        for (g = 0; g < N_CE; g++) begin : g_hit
            // One comparator per enable.
            always_comb hit[g] = (bank_idx == ADDR_W'(g));
        end
    endgenerate

    // R4: a given address falls in at most one bank.
    always_comb begin
        p_hit_onehot_r4: assert ($onehot0(hit) || $isunknown(addr));
    end

endmodule

// File: rtl/cedec_out_stage.sv
`timescale 1ns/1ps
// Module: registered output stage. Combines bank hits with the access type,
// pin enables and merge bits, and registers active-low enables.
// Assumes the low N_MERGE enables have peripheral partners; higher ones do not.
module cedec_out_stage #(
    parameter int N_CE    = 8,
    parameter int N_MERGE = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_CE-1:0]    hit,
    input  logic               is_prog,
    input  logic [N_CE-1:0]    pin_en,
    input  logic [N_MERGE-1:0] merge_bits,
    output logic [N_CE-1:0]    ce_n,
    output logic [N_MERGE-1:0] pce_n
);

    logic [N_CE-1:0]    ce_act;
    logic [N_MERGE-1:0] pce_act;

    genvar g;
    generate
        for (g = 0; g < N_CE; g++) begin : g_ce
            if (g < N_MERGE) begin : g_merged
                // Program enable; also serves data accesses when merged.
                always_comb ce_act[g]  = hit[g] && pin_en[g] && (is_prog || merge_bits[g]);
                // Peripheral enable for data accesses unless merged.
                always_comb pce_act[g] = hit[g] && !is_prog && !merge_bits[g];

                // R9: a merged bank never raises its peripheral enable.
                p_merge_quiets_pce_r9: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(merge_bits[g]) |-> pce_n[g]);
            end else begin : g_plain
                // Program-only enable.
                always_comb ce_act[g] = hit[g] && pin_en[g] && is_prog;
            end

            // R7: an I/O pin keeps its enable high.
            p_io_pin_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
                !$past(pin_en[g]) |-> ce_n[g]);
        end
    endgenerate

    // Output registers: all inactive in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ce_n  <= '1;
            pce_n <= '1;
        end else begin
            ce_n  <= ~ce_act;
            pce_n <= ~pce_act;
        end
    end

    // R4: never more than one chip enable low.
    p_single_ce_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ce_n));

    // R8: a data access without merging lowers no chip enable.
    p_data_no_ce_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!is_prog) && $past(merge_bits) == '0) |-> (ce_n == '1));

endmodule

// File: rtl/cedec_top.sv
`timescale 1ns/1ps
// Module: configurable memory chip-enable decoder top. Wires the register
// file, the bank matcher and the output stage, and expands the two
// progressive pin codes into per-pin enables.
// Assumes N_CE = 2 * N_GRP, with one pin code per group.
module cedec_top
    import cedec_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int N_GRP  = 4,
    localparam int N_CE  = 2 * N_GRP
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [1:0]        cfg_wr_sel,
    input  logic [N_GRP-1:0]  cfg_wr_data,
    input  logic [ADDR_W-1:0] fetch_addr,
    input  logic              fetch_is_prog,
    output logic [N_CE-1:0]   ce_n,
    output logic [N_GRP-1:0]  pce_n,
    output logic [N_CE-1:0]   pin_is_ce
);

    logic [2:0]       size_code;
    logic [2:0]       low_code;
    logic [2:0]       high_code;
    logic [N_GRP-1:0] merge_bits;
    logic [N_CE-1:0]  hit;
    logic [N_CE-1:0]  pin_en;

    cedec_cfg_regs #(.N_MERGE(N_GRP)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (cfg_wr_en),
        .wr_sel     (cfg_wr_sel),
        .wr_data    (cfg_wr_data),
        .size_code  (size_code),
        .low_code   (low_code),
        .high_code  (high_code),
        .merge_bits (merge_bits)
    );

    cedec_bank_sel #(.ADDR_W(ADDR_W), .N_CE(N_CE)) u_bank (
        .addr      (fetch_addr),
        .size_code (size_code),
        .hit       (hit)
    );

    genvar g;
    generate
        for (g = 0; g < N_GRP; g++) begin : g_pins
            // Progressive enable: code 1xx enables pins 0..xx of the group.
            always_comb pin_en[g]         = low_code[2]  && (g <= int'(low_code[1:0]));
            always_comb pin_en[g + N_GRP] = high_code[2] && (g <= int'(high_code[1:0]));
        end
    endgenerate

    // Pin mode output follows the pin enables.
    always_comb pin_is_ce = pin_en;

    cedec_out_stage #(.N_CE(N_CE), .N_MERGE(N_GRP)) u_out (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit        (hit),
        .is_prog    (fetch_is_prog),
        .pin_en     (pin_en),
        .merge_bits (merge_bits),
        .ce_n       (ce_n),
        .pce_n      (pce_n)
    );

    // R3: with the largest bank size, the upper enables stay high.
    p_upper_quiet_4m_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(size_code[2:1]) == 2'b11) |-> (&ce_n[N_CE-1:N_GRP]));

    // R5: a low pin code with bit 2 clear leaves the low group as I/O.
    p_low_io_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !low_code[2] |-> (pin_is_ce[N_GRP-1:0] == '0));

endmodule

// File: tb/sim_cedec_top.sv
`timescale 1ns/1ps
// Bench: sweeps every size code, every pair of pin codes and every merge
// pattern. Expected enables are computed arithmetically from bank size.
module sim_cedec_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr_en = 1'b0;
    logic [1:0]  cfg_wr_sel = '0;
    logic [3:0]  cfg_wr_data = '0;
    logic [23:0] fetch_addr = '0;
    logic        fetch_is_prog = 1'b1;
    logic [7:0]  ce_n;
    logic [3:0]  pce_n;
    logic [7:0]  pin_is_ce;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    logic [2:0] m_sz = 0, m_lo = 0, m_hi = 0;
    logic [3:0] m_mg = 0;

    always #5 clk = ~clk;

    cedec_top u0 (
        .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_sel(cfg_wr_sel),
        .cfg_wr_data(cfg_wr_data), .fetch_addr(fetch_addr), .fetch_is_prog(fetch_is_prog),
        .ce_n(ce_n), .pce_n(pce_n), .pin_is_ce(pin_is_ce)
    );

    function automatic longint bank_bytes(input logic [2:0] c);
        case (c)
            3'd0: return 64'd32768;
            3'd1: return 64'd131072;
            3'd2: return 64'd262144;
            3'd3: return 64'd524288;
            3'd4: return 64'd1 << 20;
            3'd5: return 64'd1 << 21;
            default: return 64'd1 << 22;
        endcase
    endfunction

    function automatic logic [7:0] exp_pins(input logic [2:0] lo, input logic [2:0] hi);
        logic [7:0] r = '0;
        for (int i = 0; i < 4; i++) begin
            if (lo[2] && i <= lo[1:0]) r[i] = 1'b1;
            if (hi[2] && i <= hi[1:0]) r[i+4] = 1'b1;
        end
        return r;
    endfunction

    function automatic logic [7:0] exp_ce(input longint a, input bit prog);
        longint b = a / bank_bytes(m_sz);
        logic [7:0] pins = exp_pins(m_lo, m_hi);
        logic [7:0] r = 8'hFF;
        if (b < 8 && pins[b] && (prog || (b < 4 && m_mg[b]))) r[b] = 1'b0;
        return r;
    endfunction

    function automatic logic [3:0] exp_pce(input longint a, input bit prog);
        longint b = a / bank_bytes(m_sz);
        logic [3:0] r = 4'hF;
        if (!prog && b < 4 && !m_mg[b]) r[b] = 1'b0;
        return r;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [3:0] d);
        @(negedge clk);
        cfg_wr_en = 1'b1; cfg_wr_sel = sel; cfg_wr_data = d;
        @(negedge clk);
        cfg_wr_en = 1'b0;
        case (sel)
            2'd0: m_sz = d[2:0];
            2'd1: m_lo = d[2:0];
            2'd2: m_hi = d[2:0];
            default: m_mg = d;
        endcase
    endtask

    // Drive on a falling edge, sample one period later.
    task automatic acc(input string req, input longint a, input bit prog);
        @(negedge clk);
        fetch_addr = 24'(a); fetch_is_prog = prog;
        @(negedge clk);
        chk(req, 32'(ce_n), 32'(exp_ce(a, prog)));
        chk(req, 32'(pce_n), 32'(exp_pce(a, prog)));
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state.
        repeat (2) @(negedge clk);
        chk("R1 ce_n in reset", 32'(ce_n), 32'hFF);
        chk("R1 pce_n in reset", 32'(pce_n), 32'hF);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 pin mode after reset", 32'(pin_is_ce), 32'h00);
        acc("R7 fetch with all pins I/O", 0, 1'b1);
        chk("R7 ce_n all high", 32'(ce_n), 32'hFF);
        acc("R8 data access with pins I/O", 0, 1'b0);
        chk("R8 pce0 low", 32'(pce_n), 32'hE);

        // R2 R3 R4: every size code, both sides of every bank boundary.
        wr(2'd1, 4'd7);
        wr(2'd2, 4'd7);
        for (int sz = 0; sz < 8; sz++) begin
            wr(2'd0, 4'(sz));
            for (int n = 0; n <= 8; n++) begin
                longint s = bank_bytes(3'(sz));
                longint base = n * s;
                string tag = (n >= 8) ? "R4 above last bank" :
                             (sz >= 6) ? "R3 4M bank" : "R2 bank boundary";
                if (base < 64'd16777216) acc(tag, base, 1'b1);
                if (n > 0 && base - 1 < 64'd16777216) acc(tag, base - 1, 1'b1);
            end
        end

        // R5 R6 R7: every pair of pin codes, one address per bank.
        wr(2'd0, 4'd0);
        for (int lo = 0; lo < 8; lo++) begin
            for (int hi = 0; hi < 8; hi++) begin
                wr(2'd1, 4'(lo));
                wr(2'd2, 4'(hi));
                chk("R5 low pin mode", 32'(pin_is_ce[3:0]), 32'(exp_pins(3'(lo), 3'(hi)) & 8'h0F));
                chk("R6 high pin mode", 32'(pin_is_ce[7:4]), 32'(exp_pins(3'(lo), 3'(hi)) >> 4));
                for (int b = 0; b < 8; b++) acc("R7 pin gating", b * 32768 + 77, 1'b1);
            end
        end

        // R8 R9: every merge pattern, data and program accesses per bank.
        wr(2'd1, 4'd7);
        wr(2'd2, 4'd7);
        wr(2'd0, 4'd1);
        for (int m = 0; m < 16; m++) begin
            wr(2'd3, 4'(m));
            for (int b = 0; b < 8; b++) begin
                acc("R9 merged data access", b * 131072 + 4, 1'b0);
                acc("R8 program access", b * 131072 + 131071, 1'b1);
            end
        end
        wr(2'd3, 4'd0);
        wr(2'd1, 4'd0);
        acc("R8 pce independent of pin mode", 2 * 131072, 1'b0);

        // R10: one-cycle latency and hold.
        wr(2'd1, 4'd7);
        acc("R10 first address", 2 * 131072, 1'b1);
        @(negedge clk);
        fetch_addr = 24'(5 * 131072); fetch_is_prog = 1'b1;
        #2;
        chk("R10 held before edge", 32'(ce_n), 32'(exp_ce(2 * 131072, 1'b1)));
        @(negedge clk);
        chk("R10 updated after edge", 32'(ce_n), 32'(exp_ce(5 * 131072, 1'b1)));

        // R11: select and data without strobe do nothing.
        @(negedge clk);
        cfg_wr_sel = 2'd1; cfg_wr_data = 4'd0; cfg_wr_en = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk("R11 no write without strobe", 32'(pin_is_ce), 32'(exp_pins(m_lo, m_hi)));
        wr(2'd0, 4'hF);
        acc("R11 size field from bits 2:0", 3 * (64'd1 << 22), 1'b1);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule